// File: doc/BRIEF.md
# I2C Master with Hold-on-Empty and Abort

This block is the transmit side of an I2C bus master. Software pushes 10-bit command words into a small queue. Each word carries one data byte, a direction flag and a flag that asks for a STOP condition once that byte is done. A bit sequencer turns the queue into START, data, acknowledge and STOP phases on two open-drain lines. An output enable set to 1 pulls a line low. Read bytes are handed back on a one-cycle valid strobe.

The queue can run dry in the middle of a transfer, after a byte that asked for no STOP. With the hold option built in, the sequencer does not close the transfer. It parks with the clock line pulled low and shows an on-hold flag, which lets software take its time to decide what comes next. One such case is a block read whose count byte came back as zero. Pushing a new command resumes the transfer. A self-clearing abort bit in the control word closes the transfer with a STOP, throws away any queued commands and raises a sticky abort flag. While the master is parked, a request to switch the controller off is refused until the transfer has been aborted. Built without the hold option, the sequencer closes the transfer with a STOP as soon as the queue runs dry.

Top module: `i2c_hold_master`

## Requirements
- R1: After reset both line enables are 0, `en_status` is 0, `raw_intr` is all zeros and `ctrl_rdata` is 0.
- R2: A command with bit 8 = 0 is a write. Its data bits 7:0 go out on SDA MSB first, with SDA changing only while SCL is low. Bytes leave in the order they were pushed.
- R3: A command with bit 8 = 1 is a read. The byte sampled from SDA is shown on `rx_data` with a one-cycle `rx_valid`. The master drives ACK (SDA low) after the byte, or NACK (SDA released) when bit 9 is set in that command.
- R4: A command with bit 9 = 1 ends the transfer with a STOP after its byte. Both lines are then released and `raw_intr[13]` stays 0.
- R5: With HOLD_EN = 1, the master holds SCL low when the queue is empty after a byte without bit 9. While it holds, `raw_intr[13]` reads 1.
- R6: Pushing a command while the master holds resumes the transfer with that byte, and `raw_intr[13]` returns to 0.
- R7: Writing 1 to control bit 1 (abort) lets the current byte finish, then sends a STOP, flushes the command queue and sets `raw_intr[6]`. Control bit 1 reads back 1 until the abort is complete and then clears itself. `intr_clr` clears `raw_intr[6]`.
- R8: While the master holds, writing control bit 0 (enable) as 0 has no effect: `ctrl_rdata[0]` and `en_status` stay 1 and SCL stays held.
- R9: After enable is cleared, `en_status` falls only once the sequencer is idle and at least 4*QTR clock cycles (one SCL period) have passed.
- R10: A read without bit 9 that returns 0x00 with nothing else queued leads into the hold. An abort then brings the bus back to idle with both lines released.
- R11: With HOLD_EN = 0, an empty queue after a byte without bit 9 produces a STOP on its own, and `raw_intr[13]` never becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_push | input | 1 | Push `cmd_word` into the command queue (ignored when full) |
| cmd_word | input | 10 | Bit 9 STOP, bit 8 read, bits 7:0 data |
| cmd_full | output | 1 | Command queue is full |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 2 | Bit 0 enable, bit 1 abort |
| ctrl_rdata | output | 2 | Current enable and pending-abort bits |
| en_status | output | 1 | Controller is active |
| raw_intr | output | 14 | Bit 13 on-hold (live), bit 6 transfer aborted (sticky) |
| intr_clr | input | 1 | Clears the sticky abort flag |
| rx_valid | output | 1 | One-cycle strobe: read byte ready |
| rx_data | output | 8 | Received byte |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA level seen on the bus |

## Verification
The sequencer is exercised with several command patterns. A two-byte write ending in STOP exposes bit order and queue order. A two-byte read checks the ACK/NACK choice that depends on the STOP flag. A single byte left without STOP separates hold from auto-STOP, and the bench runs it on both the hold and the no-hold build. Three things are then tried against a parked bus: a push (resume versus stuck), a disable write (refused versus obeyed) and an abort. The abort is also issued in the middle of a byte with two more commands queued, which shows whether the queue is really flushed. A zero-valued read byte stands in for the empty block-read case.

// File: rtl/i2chm_pkg.sv
`timescale 1ns/1ps
package i2chm_pkg;

  localparam int INTR_W   = 14;
  localparam int HOLD_BIT = 13;
  localparam int ABRT_BIT = 6;

  typedef struct packed {
    logic       stop;
    logic       rd;
    logic [7:0] data;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BYTE, S_HOLD, S_STOP
  } seq_st_e;

  // Where the sequencer goes after the acknowledge slot of a byte.
  function automatic seq_st_e after_byte(input logic stop, input logic enable,
                                         input logic abort, input logic empty,
                                         input logic hold_ok);
    if (stop || abort || !enable) return S_STOP;
    if (!empty)                   return S_BYTE;
    if (hold_ok)                  return S_HOLD;
    return S_STOP;
  endfunction

  // Whether the master pulls SDA low during bit n (0..7 data, 8 ack slot).
  function automatic logic bit_pull(input cmd_t c, input logic [3:0] n);
    if (n == 4'd8) return c.rd && !c.stop;
    return !c.rd && !c.data[3'd7 - n[2:0]];
  endfunction

endpackage

// File: rtl/i2chm_fifo.sv
`timescale 1ns/1ps
module i2chm_fifo
  import i2chm_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  cmd_t wdata,
  input  logic pop,
  input  logic flush,
  output cmd_t head,
  output logic empty,
  output logic full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  cmd_t          mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end

  assign head  = mem[rp];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  // R2: a push into a full queue is dropped, nothing is overwritten
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> $stable(count));

  // R7: a flush leaves the queue empty
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/i2chm_seq.sv
`timescale 1ns/1ps
module i2chm_seq
  import i2chm_pkg::*;
#(
  parameter int QTR     = 3,
  parameter int HOLD_EN = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       abort_req,
  input  logic       fifo_empty,
  input  cmd_t       fifo_head,
  output logic       fifo_pop,
  output logic       abort_done,
  output logic       on_hold,
  output logic       seq_idle,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int QW = (QTR > 1) ? $clog2(QTR) : 1;

  seq_st_e       st;
  logic [1:0]    ph;
  logic [QW-1:0] qcnt;
  logic [3:0]    bitn;
  cmd_t          cur;
  logic [7:0]    rxsh;
  logic          hold_ok;

  generate
    if (HOLD_EN != 0) begin : g_hold
      assign hold_ok = 1'b1;
    end else begin : g_nohold
      assign hold_ok = 1'b0;
    end
  endgenerate

  wire     tick     = (qcnt == QW'(QTR - 1));
  wire     byte_end = (st == S_BYTE) && tick && (ph == 2'd3) && (bitn == 4'd8);
  seq_st_e nxt_st;
  assign nxt_st = after_byte(cur.stop, enable, abort_req, fifo_empty, hold_ok);

  // named events for the control block and assertions
  assign fifo_pop   = ((st == S_START) && tick && (ph == 2'd3)) ||
                      (byte_end && (nxt_st == S_BYTE)) ||
                      ((st == S_HOLD) && !abort_req && !fifo_empty);
  assign abort_done = abort_req &&
                      ((st == S_IDLE) || ((st == S_STOP) && tick && (ph == 2'd3)));
  assign on_hold    = (st == S_HOLD);
  assign seq_idle   = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; qcnt <= '0; bitn <= '0;
      cur <= '0; rxsh <= '0; rx_data <= '0; rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          qcnt <= '0; ph <= '0;
          if (!abort_req && enable && !fifo_empty) st <= S_START;
        end
        S_START: begin
          qcnt <= tick ? '0 : qcnt + QW'(1);
          if (tick) begin
            if (ph == 2'd3) begin
              st <= S_BYTE; ph <= '0; bitn <= '0; cur <= fifo_head;
            end else ph <= ph + 2'd1;
          end
        end
        S_BYTE: begin
          qcnt <= tick ? '0 : qcnt + QW'(1);
          if (tick) begin
            if (ph == 2'd2 && bitn != 4'd8) rxsh <= {rxsh[6:0], sda_in};
            if (ph == 2'd3) begin
              ph <= '0;
              if (bitn != 4'd8) bitn <= bitn + 4'd1;
              else begin
                bitn <= '0;
                if (cur.rd) begin
                  rx_valid <= 1'b1;
                  rx_data  <= rxsh;
                end
                st <= nxt_st;
                if (nxt_st == S_BYTE) cur <= fifo_head;
              end
            end else ph <= ph + 2'd1;
          end
        end
        S_HOLD: begin
          qcnt <= '0; ph <= '0;
          if (abort_req) st <= S_STOP;
          else if (!fifo_empty) begin
            st <= S_BYTE; bitn <= '0; cur <= fifo_head;
          end
        end
        S_STOP: begin
          qcnt <= tick ? '0 : qcnt + QW'(1);
          if (tick) begin
            if (ph == 2'd3) st <= S_IDLE;
            else ph <= ph + 2'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Line drive: SCL is low in phases 0 and 3 of a bit, SDA moves only then.
  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin
        scl_oe = (ph >= 2'd2);
        sda_oe = (ph >= 2'd1);
      end
      S_BYTE: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = bit_pull(cur, bitn);
      end
      S_HOLD:  scl_oe = 1'b1;
      S_STOP: begin
        scl_oe = (ph == 2'd0);
        sda_oe = (ph <= 2'd1);
      end
      default: ;
    endcase
  end

  // R2: SDA does not move while SCL is released inside a byte
  a_r2_sda_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && $past(st == S_BYTE) && !scl_oe && $past(!scl_oe))
      |-> $stable(sda_oe));

  // R5: the hold is entered only after a byte without STOP
  a_r5_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_hold) |-> (!cur.stop && enable));

  // R6: a queued command releases the hold on the next cycle
  a_r6_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (on_hold && !fifo_empty && !abort_req) |=> !on_hold);

  // R7: an abort during the hold heads for a STOP
  a_r7_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (on_hold && abort_req) |=> (st == S_STOP));

endmodule

// File: rtl/i2chm_ctrl.sv
`timescale 1ns/1ps
module i2chm_ctrl #(
  parameter int QTR = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  input  logic       intr_clr,
  input  logic       on_hold,
  input  logic       seq_idle,
  input  logic       abort_done,
  output logic       enable,
  output logic       abort_req,
  output logic [1:0] rdata,
  output logic       en_status,
  output logic       tx_abrt
);
  localparam int PERIOD = 4 * QTR;
  localparam int CW     = $clog2(PERIOD + 1);

  logic [CW-1:0] dis_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0; abort_req <= 1'b0; tx_abrt <= 1'b0;
      en_status <= 1'b0; dis_cnt <= '0;
    end else begin
      if (wr) begin
        if (wdata[0])     enable <= 1'b1;
        else if (!on_hold) enable <= 1'b0;
      end
      if (wr && wdata[1]) abort_req <= 1'b1;
      else if (abort_done) abort_req <= 1'b0;
      if (abort_done)    tx_abrt <= 1'b1;
      else if (intr_clr) tx_abrt <= 1'b0;
      if (enable || !seq_idle)         dis_cnt <= '0;
      else if (dis_cnt != CW'(PERIOD)) dis_cnt <= dis_cnt + CW'(1);
      if (enable)                      en_status <= 1'b1;
      else if (dis_cnt == CW'(PERIOD)) en_status <= 1'b0;
    end
  end

  assign rdata = {abort_req, enable};

  // R8: holding the bus keeps the controller enabled
  a_r8_hold_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (on_hold && enable) |=> enable);

  // R7: the abort bit clears itself once the abort is complete
  a_r7_abort_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_done && !(wr && wdata[1])) |=> !abort_req);

  // R7: a finished abort raises the sticky flag
  a_r7_abrt_flag: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |=> tx_abrt);

  // R9: the active status drops only from an idle, disabled sequencer
  a_r9_status_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_status) |-> $past(!enable && seq_idle));

endmodule

// File: rtl/i2c_hold_master.sv
`timescale 1ns/1ps
module i2c_hold_master
  import i2chm_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int QTR     = 3,
  parameter int HOLD_EN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_push,
  input  logic [9:0]        cmd_word,
  output logic              cmd_full,
  input  logic              ctrl_wr,
  input  logic [1:0]        ctrl_wdata,
  output logic [1:0]        ctrl_rdata,
  output logic              en_status,
  output logic [INTR_W-1:0] raw_intr,
  input  logic              intr_clr,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  cmd_t head;
  logic empty, pop, abort_done, on_hold, seq_idle;
  logic enable, abort_req, tx_abrt;

  i2chm_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .wdata(cmd_t'(cmd_word)),
    .pop(pop), .flush(abort_done), .head(head), .empty(empty), .full(cmd_full)
  );

  i2chm_seq #(.QTR(QTR), .HOLD_EN(HOLD_EN)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .abort_req(abort_req),
    .fifo_empty(empty), .fifo_head(head), .fifo_pop(pop),
    .abort_done(abort_done), .on_hold(on_hold), .seq_idle(seq_idle),
    .rx_valid(rx_valid), .rx_data(rx_data), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_in)
  );

  i2chm_ctrl #(.QTR(QTR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata),
    .intr_clr(intr_clr), .on_hold(on_hold), .seq_idle(seq_idle),
    .abort_done(abort_done), .enable(enable), .abort_req(abort_req),
    .rdata(ctrl_rdata), .en_status(en_status), .tx_abrt(tx_abrt)
  );

  always_comb begin
    raw_intr           = '0;
    raw_intr[HOLD_BIT] = on_hold;
    raw_intr[ABRT_BIT] = tx_abrt;
  end

  // R4: with the hold built out, the on-hold bit never rises
  a_r4_r11_no_hold_variant: assert property (@(posedge clk) disable iff (!rst_n)
    (HOLD_EN == 0) |-> !raw_intr[HOLD_BIT]);

endmodule

// File: tb/sim_i2c_hold_master.sv
`timescale 1ns/1ps
module sim_i2c_hold_master;
  localparam int QTR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // u0: hold build
  logic cmd_push = 0, ctrl_wr = 0, intr_clr = 0;
  logic [9:0] cmd_word = '0;
  logic [1:0] ctrl_wdata = '0;
  logic cmd_full, en_status, rx_valid, scl_oe, sda_oe;
  logic [1:0] ctrl_rdata;
  logic [13:0] raw_intr;
  logic [7:0] rx_data;
  logic slv_low = 1'b0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || slv_low);

  i2c_hold_master #(.DEPTH(4), .QTR(QTR), .HOLD_EN(1)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_word(cmd_word),
    .cmd_full(cmd_full), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .en_status(en_status), .raw_intr(raw_intr),
    .intr_clr(intr_clr), .rx_valid(rx_valid), .rx_data(rx_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda));

  // u1: build without hold
  logic u1_push = 0, u1_wr = 0;
  logic [9:0] u1_word = '0;
  logic [1:0] u1_wdata = '0;
  logic u1_full, u1_en, u1_rxv, u1_scl_oe, u1_sda_oe;
  logic [1:0] u1_rdata;
  logic [13:0] u1_intr;
  logic [7:0] u1_rxd;
  wire u1_sda = !u1_sda_oe;

  i2c_hold_master #(.DEPTH(4), .QTR(QTR), .HOLD_EN(0)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_push(u1_push), .cmd_word(u1_word),
    .cmd_full(u1_full), .ctrl_wr(u1_wr), .ctrl_wdata(u1_wdata),
    .ctrl_rdata(u1_rdata), .en_status(u1_en), .raw_intr(u1_intr),
    .intr_clr(1'b0), .rx_valid(u1_rxv), .rx_data(u1_rxd),
    .scl_oe(u1_scl_oe), .sda_oe(u1_sda_oe), .sda_in(u1_sda));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0] exp_wr[$];
  logic [7:0] exp_rd[$];
  string      rd_tag[$];
  logic [9:0] slv_q[$];

  // slave model: items are {stop, rd, data}
  logic pscl = 1, psda = 1, in_xfer = 0, have = 0;
  logic [9:0] item = '0;
  logic [7:0] shift = '0;
  int bitc = 0, stop_cnt = 0;

  function automatic logic drv(input logic [9:0] it, input int b);
    if (it[8]) return (b < 8) && !it[7 - b];
    return b == 8;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl && pscl && psda && !sda) begin
        in_xfer = 1; bitc = 0; have = 0;
      end else if (scl && pscl && !psda && sda) begin
        in_xfer = 0; have = 0; slv_low = 0; stop_cnt++;
      end else if (in_xfer) begin
        if (scl && !pscl) begin
          if (bitc == 8) begin
            if (have && item[8]) begin
              chk("R3", "ack level after read byte", {31'd0, sda}, {31'd0, item[9]});
            end else if (exp_wr.size() == 0) begin
              chk("R7", "unexpected byte on bus", {24'd0, shift}, 32'hFFFF_FFFF);
            end else begin
              chk("R2", "written byte", {24'd0, shift}, {24'd0, exp_wr.pop_front()});
            end
            bitc = 0; have = 0;
          end else begin
            shift = {shift[6:0], sda}; bitc++;
          end
        end else if (!scl) begin
          if (!have && bitc == 0 && slv_q.size() > 0) begin
            item = slv_q.pop_front(); have = 1;
          end
          slv_low = have ? drv(item, bitc) : 1'b0;
        end
      end
    end
    pscl = scl; psda = sda;
  end

  // read monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_rd.size() == 0)
        chk("R3", "unexpected read strobe", {24'd0, rx_data}, 32'hFFFF_FFFF);
      else
        chk(rd_tag.pop_front(), "read byte", {24'd0, rx_data}, {24'd0, exp_rd.pop_front()});
    end
  end

  // u1 bus watcher
  logic u1_hold_seen = 0;
  int   u1_stops = 0;
  logic u1_pscl = 1, u1_psda = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (u1_intr[13]) u1_hold_seen = 1;
      if (!u1_scl_oe && u1_pscl && !u1_psda && u1_sda) u1_stops++;
    end
    u1_pscl = !u1_scl_oe; u1_psda = u1_sda;
  end

  // driver
  task automatic send(input bit stp, input bit rd, input logic [7:0] d,
                      input bit expect_it, input string tag);
    @(negedge clk);
    cmd_word = {stp, rd, d}; cmd_push = 1;
    slv_q.push_back({stp, rd, d});
    if (expect_it) begin
      if (rd) begin exp_rd.push_back(d); rd_tag.push_back(tag); end
      else exp_wr.push_back(d);
    end
    @(negedge clk);
    cmd_push = 0;
  endtask

  task automatic ctrl_write(input logic [1:0] v);
    @(negedge clk);
    ctrl_wdata = v; ctrl_wr = 1;
    @(negedge clk);
    ctrl_wr = 0;
  endtask

  task automatic wait_stop(input int base);
    for (int i = 0; i < 3000 && stop_cnt <= base; i++) @(negedge clk);
  endtask

  task automatic wait_hold();
    for (int i = 0; i < 400 && !raw_intr[13]; i++) @(negedge clk);
  endtask

  task automatic wait_abort();
    for (int i = 0; i < 400 && ctrl_rdata[1]; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, lowcnt, n;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "scl_oe", {31'd0, scl_oe}, 0);
    chk("R1", "sda_oe", {31'd0, sda_oe}, 0);
    chk("R1", "en_status", {31'd0, en_status}, 0);
    chk("R1", "raw_intr", {18'd0, raw_intr}, 0);
    chk("R1", "ctrl_rdata", {30'd0, ctrl_rdata}, 0);

    ctrl_write(2'b01);
    @(negedge clk); u1_wdata = 2'b01; u1_wr = 1; @(negedge clk); u1_wr = 0;
    chk("R9", "en_status after enable", {31'd0, en_status}, 1);

    // writes, MSB first, in order, STOP on the last (R2, R4)
    base = stop_cnt;
    send(0, 0, 8'hA5, 1, "R2");
    send(1, 0, 8'h3C, 1, "R2");
    wait_stop(base);
    repeat (4) @(negedge clk);
    chk("R2", "all written bytes seen", exp_wr.size(), 0);
    chk("R4", "stop count", stop_cnt, base + 1);
    chk("R4", "lines released", {30'd0, scl_oe, sda_oe}, 0);
    chk("R4", "no hold after stop", {31'd0, raw_intr[13]}, 0);

    // reads: ACK then NACK with STOP (R3)
    base = stop_cnt;
    send(0, 1, 8'h5A, 1, "R3");
    send(1, 1, 8'hC3, 1, "R3");
    wait_stop(base);
    repeat (4) @(negedge clk);
    chk("R3", "all read bytes seen", exp_rd.size(), 0);

    // hold on empty queue (R5), disable refused (R8), resume (R6)
    base = stop_cnt;
    send(0, 0, 8'h11, 1, "R2");
    wait_hold();
    chk("R5", "on-hold bit set", {31'd0, raw_intr[13]}, 1);
    lowcnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!scl_oe) lowcnt++;
    end
    chk("R5", "cycles with SCL released during hold", lowcnt, 0);
    ctrl_write(2'b00);
    repeat (20) @(negedge clk);
    chk("R8", "enable bit kept", {31'd0, ctrl_rdata[0]}, 1);
    chk("R8", "en_status kept", {31'd0, en_status}, 1);
    chk("R8", "still holding SCL", {31'd0, scl_oe}, 1);
    send(1, 0, 8'h22, 1, "R6");
    repeat (2) @(negedge clk);
    chk("R6", "on-hold cleared by push", {31'd0, raw_intr[13]}, 0);
    wait_stop(base);
    repeat (4) @(negedge clk);
    chk("R6", "resumed byte delivered", exp_wr.size(), 0);

    // zero-count read leads to hold, abort recovers (R10, R7)
    base = stop_cnt;
    send(0, 1, 8'h00, 1, "R10");
    wait_hold();
    chk("R10", "hold after zero-count read", {31'd0, raw_intr[13]}, 1);
    ctrl_write(2'b11);
    chk("R7", "abort bit pending", {31'd0, ctrl_rdata[1]}, 1);
    wait_abort();
    wait_stop(base);
    repeat (4) @(negedge clk);
    chk("R7", "abort bit self-cleared", {31'd0, ctrl_rdata[1]}, 0);
    chk("R10", "lines released after abort", {30'd0, scl_oe, sda_oe}, 0);
    chk("R10", "on-hold cleared", {31'd0, raw_intr[13]}, 0);
    chk("R7", "abort flag set", {31'd0, raw_intr[6]}, 1);
    chk("R10", "read byte delivered", exp_rd.size(), 0);
    @(negedge clk); intr_clr = 1; @(negedge clk); intr_clr = 0;
    chk("R7", "abort flag cleared", {31'd0, raw_intr[6]}, 0);

    // abort in the middle of a byte with commands queued: flush (R7)
    base = stop_cnt;
    send(0, 0, 8'h77, 1, "R7");
    send(0, 0, 8'h88, 0, "R7");
    send(0, 0, 8'h99, 0, "R7");
    repeat (20) @(negedge clk);
    ctrl_write(2'b11);
    wait_abort();
    repeat (300) @(negedge clk);
    chk("R7", "only first byte sent", exp_wr.size(), 0);
    chk("R7", "one stop after abort", stop_cnt, base + 1);
    chk("R7", "bus idle after flush", {30'd0, scl_oe, sda_oe}, 0);
    chk("R7", "abort flag set mid-byte", {31'd0, raw_intr[6]}, 1);
    slv_q.delete();

    // disable: status falls one SCL period later (R9)
    ctrl_write(2'b00);
    chk("R9", "enable bit cleared", {31'd0, ctrl_rdata[0]}, 0);
    n = 0;
    while (en_status && n < 100) begin @(negedge clk); n++; end
    chk("R9", "en_status fell not early", {31'd0, n >= 4 * QTR}, 1);
    chk("R9", "en_status fell in time", {31'd0, n <= 4 * QTR + 4}, 1);

    // build without hold: auto STOP (R11)
    @(negedge clk); u1_word = {2'b00, 8'h42}; u1_push = 1;
    @(negedge clk); u1_push = 0;
    repeat (400) @(negedge clk);
    chk("R11", "on-hold never seen", {31'd0, u1_hold_seen}, 0);
    chk("R11", "stop generated", u1_stops, 1);
    chk("R11", "lines released", {30'd0, u1_scl_oe, u1_sda_oe}, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule